// File: doc/BRIEF.md
# Extended 64-bit Integer ALU

This block is the integer arithmetic and logic stage of a 64-bit core. It takes two 64-bit operands and a 7-bit operation code, and returns a 64-bit result in the same cycle. It has no state, no clock and no handshake. The stage that feeds it holds the operands and the code, and it takes the result directly.

The operation code is split into a 3-bit group field, op[6:4], and a 4-bit selector, op[3:0]. The group field sends the request to one of four parallel sub-units:

- shift and single-bit operations, which also handle the word shifts;
- additions, including the word and fused add forms;
- subtract and compare;
- logic, byte manipulation and truncated logic.

Each sub-unit reports whether it recognised the code. The top ORs the result of the one sub-unit that did. A code that no sub-unit claims gives zero.

Besides the usual base and bit-manipulation operations, the ALU supports several fused forms:

- right-shift-then-add;
- add of only bit 0 of the first operand;
- a 32-bit immediate-build add;
- sums and logic results cut down to a bit, a byte or a halfword.

Top module: `xalu`

## Requirements
- R1: Shifts and rotates, with the amount taken from src_b[5:0]. The codes are: 0000000 = zero-extend src_a[31:0] and then shift left; 0000001 = shift left; 0000101 = logical shift right; 0000111 = arithmetic shift right; 0001001 = rotate left; 0001011 = rotate right.
- R2: Single-bit operations, with the bit index taken from src_b[5:0]. The codes are: 0000010 clears the bit; 0000011 sets the bit; 0000100 inverts the bit; 0000110 returns bit 0 of (src_a >> index), zero-extended.
- R3: Word operations compute on 32 bits and sign-extend bit 31 of the result to 64 bits. Shift amounts come from src_b[4:0]. The codes are: 0010000 add; 0010010 subtract; 0011000 shift left; 0011001 logical shift right of src_a[31:0]; 0011010 arithmetic shift right of src_a[31:0]; 0011100 rotate left; 0011101 rotate right.
- R4: Word add variants. Let S = src_a + src_b. The codes are: 0010100 gives S[0]; 0010101 gives S[7:0] zero-extended; 0010110 gives S[15:0] zero-extended; 0010111 gives S[15:0] sign-extended; 0010001 gives (src_a[0] + src_b)[31:0] sign-extended.
- R5: Plain adds. The codes are: 0100001 = src_a + src_b; 0100000 = zero-extended src_a[31:0] + src_b; 0100010 = src_a[0] + src_b.
- R6: Shift-and-add returns (X << k) + src_b. X is src_a, or zero-extended src_a[31:0] for the unsigned-word forms. The codes are: 0101000 k=1 unsigned-word; 0101001 k=1; 0101010 k=2 unsigned-word; 0101011 k=2; 0101100 k=3 unsigned-word; 0101101 k=3; 0101111 k=4.
- R7: Shift-right-then-add returns (src_a >> k) + src_b, using a logical shift. The codes 0100100, 0100101, 0100110 and 0100111 give k = 29, 30, 31 and 32.
- R8: Immediate-build add. Code 0100011 returns sext64(src_b[11:0]) + {src_b[63:12], 12'b0}. Code 0010011 does the same on 32 bits, using src_b[31:12], and sign-extends the 32-bit sum to 64 bits.
- R9: Compare group. The codes are: 0110000 = src_a − src_b; 0110001 = unsigned less-than (result 1 or 0); 0110010 = signed less-than; 0110100 = unsigned max; 0110101 = unsigned min; 0110110 = signed max; 0110111 = signed min.
- R10: Plain logic. The codes are: 1000000 and; 1000001 = src_a & ~src_b; 1000010 or; 1000011 = src_a | ~src_b; 1000100 xor; 1000101 xnor; 1000110 sets each byte of src_a to 0xFF if it is nonzero and to 0x00 if it is zero.
- R11: Byte manipulation. The codes are: 1001000 sign-extends src_a[7:0]; 1001010 sign-extends src_a[15:0]; 1001001 gives the zero-extended value {src_b[7:0], src_a[7:0]}; 1001011 gives sext64({src_b[15:0], src_a[15:0]}); 1010010 gives {src_b[31:0], src_a[31:0]}; 1010001 reverses the byte order of src_a.
- R12: Truncated logic. Code 110_sss_t first computes the R10 operation with code 1000sss, for sss from 000 to 110. If t = 0, the result is bit 0 of that value, zero-extended. If t = 1, the result is its low 16 bits, zero-extended.
- R13: Every code not listed in R1 to R12 returns zero. This covers, for example, 0001000, 0101110, 1111111 and 110111t.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand; also supplies shift amounts, bit indices and the immediate |
| op | input | 7 | Operation code; bits 6:4 select the group |
| result | output | 64 | Combinational result |

## Verification
The hardest cases to reach are the ones that depend on exact operand values:

- a shift or rotate amount of exactly 0, 31, 32 or 63, where the two words seam together;
- the sign bit at bit 31 or at bit 11 of the immediate, which decides the extension;
- min and max on values where signed and unsigned order disagree.

The stimulus crosses every one of the 128 codes with a grid of 16 hand-chosen operand values on each side. The grid includes those shift amounts, single-bit sign patterns and mixed-sign pairs. A run of pseudo-random operand pairs is then applied to every code. Invalid codes are therefore exercised with nonzero operands and must still return zero.

// File: rtl/xalu_pkg.sv
package xalu_pkg;

    localparam int unsigned XLEN   = 64;
    localparam int unsigned HALF   = XLEN / 2;
    localparam int unsigned SHW    = $clog2(XLEN);
    localparam int unsigned NBYTE  = XLEN / 8;
    localparam int unsigned OPW    = 7;

    typedef logic [OPW-1:0]  opc_t;
    typedef logic [XLEN-1:0] word_t;

    typedef struct packed {
        logic  hit;
        word_t val;
    } unit_out_t;

    // group 000: shift and bit ops
    localparam opc_t OP_SHL_UW  = 7'b000_0000;
    localparam opc_t OP_SHL     = 7'b000_0001;
    localparam opc_t OP_BIT_CLR = 7'b000_0010;
    localparam opc_t OP_BIT_SET = 7'b000_0011;
    localparam opc_t OP_BIT_INV = 7'b000_0100;
    localparam opc_t OP_SHR     = 7'b000_0101;
    localparam opc_t OP_BIT_GET = 7'b000_0110;
    localparam opc_t OP_SHRA    = 7'b000_0111;
    localparam opc_t OP_ROTL    = 7'b000_1001;
    localparam opc_t OP_ROTR    = 7'b000_1011;
    // group 001: word ops
    localparam opc_t OP_W_ADD   = 7'b001_0000;
    localparam opc_t OP_W_ODD   = 7'b001_0001;
    localparam opc_t OP_W_SUB   = 7'b001_0010;
    localparam opc_t OP_W_IMMB  = 7'b001_0011;
    localparam opc_t OP_W_SBIT  = 7'b001_0100;
    localparam opc_t OP_W_SBYTE = 7'b001_0101;
    localparam opc_t OP_W_SZH   = 7'b001_0110;
    localparam opc_t OP_W_SSH   = 7'b001_0111;
    localparam opc_t OP_W_SHL   = 7'b001_1000;
    localparam opc_t OP_W_SHR   = 7'b001_1001;
    localparam opc_t OP_W_SHRA  = 7'b001_1010;
    localparam opc_t OP_W_ROTL  = 7'b001_1100;
    localparam opc_t OP_W_ROTR  = 7'b001_1101;
    // group 010: add family
    localparam opc_t OP_ADD_UW  = 7'b010_0000;
    localparam opc_t OP_ADD     = 7'b010_0001;
    localparam opc_t OP_ADD_ODD = 7'b010_0010;
    localparam opc_t OP_ADD_IMB = 7'b010_0011;
    localparam opc_t OP_SR29A   = 7'b010_0100;
    localparam opc_t OP_SR30A   = 7'b010_0101;
    localparam opc_t OP_SR31A   = 7'b010_0110;
    localparam opc_t OP_SR32A   = 7'b010_0111;
    localparam opc_t OP_SL1A_UW = 7'b010_1000;
    localparam opc_t OP_SL1A    = 7'b010_1001;
    localparam opc_t OP_SL2A_UW = 7'b010_1010;
    localparam opc_t OP_SL2A    = 7'b010_1011;
    localparam opc_t OP_SL3A_UW = 7'b010_1100;
    localparam opc_t OP_SL3A    = 7'b010_1101;
    localparam opc_t OP_SL4A    = 7'b010_1111;
    // group 011: subtract and compare
    localparam opc_t OP_SUB     = 7'b011_0000;
    localparam opc_t OP_LTU     = 7'b011_0001;
    localparam opc_t OP_LTS     = 7'b011_0010;
    localparam opc_t OP_MAXU    = 7'b011_0100;
    localparam opc_t OP_MINU    = 7'b011_0101;
    localparam opc_t OP_MAXS    = 7'b011_0110;
    localparam opc_t OP_MINS    = 7'b011_0111;
    // groups 100/101: logic and byte manipulation
    localparam opc_t OP_SXB     = 7'b100_1000;
    localparam opc_t OP_PACK_LB = 7'b100_1001;
    localparam opc_t OP_SXH     = 7'b100_1010;
    localparam opc_t OP_PACK_WH = 7'b100_1011;
    localparam opc_t OP_BSWAP   = 7'b101_0001;
    localparam opc_t OP_PACK_LW = 7'b101_0010;

    localparam logic [2:0] GRP_LOGIC = 3'b100;
    localparam logic [2:0] GRP_TRUNC = 3'b110;

    function automatic word_t sext_half(input logic [HALF-1:0] x);
        return {{HALF{x[HALF-1]}}, x};
    endfunction

    function automatic word_t zext_half(input logic [HALF-1:0] x);
        return {{HALF{1'b0}}, x};
    endfunction

endpackage

// File: rtl/xalu_shift_unit.sv
module xalu_shift_unit
    import xalu_pkg::*;
(
    input  opc_t             op,
    input  word_t            a,
    input  logic [SHW-1:0]   amt,
    output unit_out_t        out
);
    localparam int unsigned WSHW = SHW - 1;

    unit_out_t        res_d;
    logic [2*XLEN-1:0] dbl_l;
    logic [2*XLEN-1:0] dbl_r;
    logic [2*HALF-1:0] dblw_l;
    logic [2*HALF-1:0] dblw_r;
    logic [WSHW-1:0]   wamt;
    logic [HALF-1:0]   a_lo;
    word_t             onehot_bit;

    always_comb begin
        wamt       = amt[WSHW-1:0];
        a_lo       = a[HALF-1:0];
        onehot_bit = word_t'(1) << amt;
        dbl_l      = {a, a} << amt;
        dbl_r      = {a, a} >> amt;
        dblw_l     = {a_lo, a_lo} << wamt;
        dblw_r     = {a_lo, a_lo} >> wamt;
        res_d      = '0;
        res_d.hit  = 1'b1;
        case (op)
            OP_SHL_UW:  res_d.val = zext_half(a_lo) << amt;
            OP_SHL:     res_d.val = a << amt;
            OP_BIT_CLR: res_d.val = a & ~onehot_bit;
            OP_BIT_SET: res_d.val = a | onehot_bit;
            OP_BIT_INV: res_d.val = a ^ onehot_bit;
            OP_SHR:     res_d.val = a >> amt;
            OP_BIT_GET: res_d.val = word_t'(a[amt]);
            OP_SHRA:    res_d.val = word_t'($signed(a) >>> amt);
            OP_ROTL:    res_d.val = dbl_l[2*XLEN-1:XLEN];
            OP_ROTR:    res_d.val = dbl_r[XLEN-1:0];
            OP_W_SHL:   res_d.val = sext_half(a_lo << wamt);
            OP_W_SHR:   res_d.val = sext_half(a_lo >> wamt);
            OP_W_SHRA:  res_d.val = sext_half(HALF'($signed(a_lo) >>> wamt));
            OP_W_ROTL:  res_d.val = sext_half(dblw_l[2*HALF-1:HALF]);
            OP_W_ROTR:  res_d.val = sext_half(dblw_r[HALF-1:0]);
            default: begin
                res_d.hit = 1'b0;
                res_d.val = '0;
            end
        endcase
    end

    assign out = res_d;

    // R2: the single-bit ops touch at most the indexed bit of src_a
    always_comb begin
        if (op == OP_BIT_CLR || op == OP_BIT_SET || op == OP_BIT_INV) begin
            a_r2_one_bit_touched: assert ($countones(out.val ^ a) <= 1)
                else $error("single-bit op changed more than one bit");
        end
    end

endmodule

// File: rtl/xalu_add_unit.sv
module xalu_add_unit
    import xalu_pkg::*;
(
    input  opc_t      op,
    input  word_t     a,
    input  word_t     b,
    output unit_out_t out
);
    localparam int unsigned IMMW = 12;

    unit_out_t       res_d;
    word_t           sum;
    word_t           dif;
    word_t           odd_sum;
    word_t           a_uw;
    word_t           imm_full;
    logic [HALF-1:0] imm_half;

    always_comb begin
        sum      = a + b;
        dif      = a - b;
        odd_sum  = word_t'(a[0]) + b;
        a_uw     = zext_half(a[HALF-1:0]);
        imm_full = {{(XLEN-IMMW){b[IMMW-1]}}, b[IMMW-1:0]}
                 + {b[XLEN-1:IMMW], {IMMW{1'b0}}};
        imm_half = {{(HALF-IMMW){b[IMMW-1]}}, b[IMMW-1:0]}
                 + {b[HALF-1:IMMW], {IMMW{1'b0}}};
        res_d     = '0;
        res_d.hit = 1'b1;
        case (op)
            OP_W_ADD:   res_d.val = sext_half(sum[HALF-1:0]);
            OP_W_ODD:   res_d.val = sext_half(odd_sum[HALF-1:0]);
            OP_W_SUB:   res_d.val = sext_half(dif[HALF-1:0]);
            OP_W_IMMB:  res_d.val = sext_half(imm_half);
            OP_W_SBIT:  res_d.val = word_t'(sum[0]);
            OP_W_SBYTE: res_d.val = word_t'(sum[7:0]);
            OP_W_SZH:   res_d.val = word_t'(sum[15:0]);
            OP_W_SSH:   res_d.val = {{(XLEN-16){sum[15]}}, sum[15:0]};
            OP_ADD_UW:  res_d.val = a_uw + b;
            OP_ADD:     res_d.val = sum;
            OP_ADD_ODD: res_d.val = odd_sum;
            OP_ADD_IMB: res_d.val = imm_full;
            OP_SR29A:   res_d.val = (a >> 29) + b;
            OP_SR30A:   res_d.val = (a >> 30) + b;
            OP_SR31A:   res_d.val = (a >> 31) + b;
            OP_SR32A:   res_d.val = (a >> 32) + b;
            OP_SL1A_UW: res_d.val = (a_uw << 1) + b;
            OP_SL1A:    res_d.val = (a << 1) + b;
            OP_SL2A_UW: res_d.val = (a_uw << 2) + b;
            OP_SL2A:    res_d.val = (a << 2) + b;
            OP_SL3A_UW: res_d.val = (a_uw << 3) + b;
            OP_SL3A:    res_d.val = (a << 3) + b;
            OP_SL4A:    res_d.val = (a << 4) + b;
            default: begin
                res_d.hit = 1'b0;
                res_d.val = '0;
            end
        endcase
    end

    assign out = res_d;

    // R4: the zero-extended halfword and sign-extended halfword forms agree on the low 16 bits
    always_comb begin
        if (op == OP_W_SSH) begin
            a_r4_half_forms_agree: assert (out.val[15:0] == (a[15:0] + b[15:0]))
                else $error("halfword sum mismatch");
        end
    end

endmodule

// File: rtl/xalu_cmp_unit.sv
module xalu_cmp_unit
    import xalu_pkg::*;
(
    input  opc_t      op,
    input  word_t     a,
    input  word_t     b,
    output unit_out_t out
);
    unit_out_t res_d;
    logic      lt_u;
    logic      lt_s;

    always_comb begin
        lt_u      = a < b;
        lt_s      = $signed(a) < $signed(b);
        res_d     = '0;
        res_d.hit = 1'b1;
        case (op)
            OP_SUB:  res_d.val = a - b;
            OP_LTU:  res_d.val = word_t'(lt_u);
            OP_LTS:  res_d.val = word_t'(lt_s);
            OP_MAXU: res_d.val = lt_u ? b : a;
            OP_MINU: res_d.val = lt_u ? a : b;
            OP_MAXS: res_d.val = lt_s ? b : a;
            OP_MINS: res_d.val = lt_s ? a : b;
            default: begin
                res_d.hit = 1'b0;
                res_d.val = '0;
            end
        endcase
    end

    assign out = res_d;

    // R9: min and max return one of the two operands; subtract inverts add
    always_comb begin
        if (op == OP_MAXU || op == OP_MINU || op == OP_MAXS || op == OP_MINS) begin
            a_r9_minmax_pick: assert (out.val == a || out.val == b)
                else $error("min/max returned neither operand");
        end
        if (op == OP_SUB) begin
            a_r9_sub_inverse: assert (out.val + b == a)
                else $error("difference plus src_b differs from src_a");
        end
    end

endmodule

// File: rtl/xalu_logic_unit.sv
module xalu_logic_unit
    import xalu_pkg::*;
(
    input  opc_t      op,
    input  word_t     a,
    input  word_t     b,
    output unit_out_t out
);
    unit_out_t  res_d;
    word_t      orc_w;
    word_t      bswap_w;
    word_t      base;
    logic       base_ok;
    logic [2:0] sel;
    logic [2:0] grp;

    for (genvar g = 0; g < NBYTE; g++) begin : g_byte
        assign orc_w[8*g +: 8]   = {8{|a[8*g +: 8]}};
        assign bswap_w[8*g +: 8] = a[8*(NBYTE-1-g) +: 8];
    end

    always_comb begin
        grp = op[6:4];
        // plain logic selector comes from op[2:0]; the truncated form moves it to op[3:1]
        sel = (grp == GRP_TRUNC) ? op[3:1] : op[2:0];
        base_ok = 1'b1;
        case (sel)
            3'b000:  base = a & b;
            3'b001:  base = a & ~b;
            3'b010:  base = a | b;
            3'b011:  base = a | ~b;
            3'b100:  base = a ^ b;
            3'b101:  base = ~(a ^ b);
            3'b110:  base = orc_w;
            default: begin
                base    = '0;
                base_ok = 1'b0;
            end
        endcase

        res_d = '0;
        if (grp == GRP_LOGIC && !op[3]) begin
            res_d.hit = base_ok;
            res_d.val = base_ok ? base : '0;
        end else if (grp == GRP_TRUNC) begin
            res_d.hit = base_ok;
            if (!base_ok)   res_d.val = '0;
            else if (op[0]) res_d.val = word_t'(base[15:0]);
            else            res_d.val = word_t'(base[0]);
        end else begin
            res_d.hit = 1'b1;
            case (op)
                OP_SXB:     res_d.val = {{(XLEN-8){a[7]}}, a[7:0]};
                OP_SXH:     res_d.val = {{(XLEN-16){a[15]}}, a[15:0]};
                OP_PACK_LB: res_d.val = word_t'({b[7:0], a[7:0]});
                OP_PACK_WH: res_d.val = sext_half({b[15:0], a[15:0]});
                OP_PACK_LW: res_d.val = {b[HALF-1:0], a[HALF-1:0]};
                OP_BSWAP:   res_d.val = bswap_w;
                default: begin
                    res_d.hit = 1'b0;
                    res_d.val = '0;
                end
            endcase
        end
    end

    assign out = res_d;

    // R12: the truncated forms never carry bits above their window
    always_comb begin
        if (grp == GRP_TRUNC) begin
            a_r12_trunc_window: assert ((op[0] ? out.val[XLEN-1:16] : out.val[XLEN-1:1]) == '0)
                else $error("truncated logic result exceeds its width");
        end
    end

endmodule

// File: rtl/xalu.sv
module xalu
    import xalu_pkg::*;
(
    input  logic [63:0] src_a,
    input  logic [63:0] src_b,
    input  logic [6:0]  op,
    output logic [63:0] result
);
    localparam int unsigned NUNIT = 4;

    unit_out_t          unit_q [NUNIT];
    logic [NUNIT-1:0]   hits;
    word_t              res_d;

    xalu_shift_unit u_shift (
        .op  (op),
        .a   (src_a),
        .amt (src_b[SHW-1:0]),
        .out (unit_q[0])
    );

    xalu_add_unit u_add (
        .op  (op),
        .a   (src_a),
        .b   (src_b),
        .out (unit_q[1])
    );

    xalu_cmp_unit u_cmp (
        .op  (op),
        .a   (src_a),
        .b   (src_b),
        .out (unit_q[2])
    );

    xalu_logic_unit u_logic (
        .op  (op),
        .a   (src_a),
        .b   (src_b),
        .out (unit_q[3])
    );

    always_comb begin
        res_d = '0;
        for (int i = 0; i < NUNIT; i++) begin
            hits[i] = unit_q[i].hit;
            if (unit_q[i].hit) res_d = res_d | unit_q[i].val;
        end
    end

    assign result = res_d;

    // R13: at most one sub-unit claims a code; an unclaimed code leaves the result at zero
    always_comb begin
        a_r13_single_claim: assert ($onehot0(hits))
            else $error("more than one sub-unit claimed op %b", op);
        if (hits == '0) begin
            a_r13_unclaimed_zero: assert (result == '0)
                else $error("unclaimed op %b gave nonzero result", op);
        end
    end

endmodule

// File: tb/xalu_tb.sv
module xalu_tb;
    logic        clk = 1'b0;
    logic [63:0] src_a;
    logic [63:0] src_b;
    logic [6:0]  op;
    logic [63:0] result;
    int          n_vec  = 0;
    int          n_fail = 0;
    logic [63:0] rng    = 64'h9E37_79B9_7F4A_7C15;

    always #2 clk = ~clk;

    xalu u_dut (.src_a(src_a), .src_b(src_b), .op(op), .result(result));

    function automatic logic [63:0] sx32(input logic [31:0] w);
        return {{32{w[31]}}, w};
    endfunction

    function automatic logic [63:0] plain_logic(input logic [2:0] s, input logic [63:0] a, input logic [63:0] b);
        logic [63:0] r;
        r = '0;
        case (s)
            3'd0: r = a & b;
            3'd1: r = a & ~b;
            3'd2: r = a | b;
            3'd3: r = a | ~b;
            3'd4: r = a ^ b;
            3'd5: r = ~(a ^ b);
            3'd6: for (int k = 0; k < 8; k++) r[8*k +: 8] = (a[8*k +: 8] != 0) ? 8'hFF : 8'h00;
            default: r = '0;
        endcase
        return r;
    endfunction

    // expected result and the requirement tag for each code
    function automatic logic [63:0] model(input logic [6:0] c, input logic [63:0] a, input logic [63:0] b, output string tag);
        logic [63:0] r, s64;
        logic [31:0] w;
        int sh, ws;
        r = '0; w = '0; sh = int'(b[5:0]); ws = int'(b[4:0]); s64 = a + b; tag = "R13";
        case (c)
            7'b0000000: begin tag = "R1"; r = {32'b0, a[31:0]} << sh; end
            7'b0000001: begin tag = "R1"; r = a << sh; end
            7'b0000101: begin tag = "R1"; r = a >> sh; end
            7'b0000111: begin tag = "R1"; for (int i = 0; i < 64; i++) r[i] = (i + sh < 64) ? a[i+sh] : a[63]; end
            7'b0001001: begin tag = "R1"; for (int i = 0; i < 64; i++) r[(i+sh)%64] = a[i]; end
            7'b0001011: begin tag = "R1"; for (int i = 0; i < 64; i++) r[i] = a[(i+sh)%64]; end
            7'b0000010: begin tag = "R2"; r = a; r[sh] = 1'b0; end
            7'b0000011: begin tag = "R2"; r = a; r[sh] = 1'b1; end
            7'b0000100: begin tag = "R2"; r = a; r[sh] = ~a[sh]; end
            7'b0000110: begin tag = "R2"; r = {63'b0, a[sh]}; end
            7'b0010000: begin tag = "R3"; r = sx32(a[31:0] + b[31:0]); end
            7'b0010010: begin tag = "R3"; r = sx32(a[31:0] - b[31:0]); end
            7'b0011000: begin tag = "R3"; r = sx32(a[31:0] << ws); end
            7'b0011001: begin tag = "R3"; r = sx32(a[31:0] >> ws); end
            7'b0011010: begin tag = "R3"; for (int i = 0; i < 32; i++) w[i] = (i + ws < 32) ? a[i+ws] : a[31]; r = sx32(w); end
            7'b0011100: begin tag = "R3"; for (int i = 0; i < 32; i++) w[(i+ws)%32] = a[i]; r = sx32(w); end
            7'b0011101: begin tag = "R3"; for (int i = 0; i < 32; i++) w[i] = a[(i+ws)%32]; r = sx32(w); end
            7'b0010001: begin tag = "R4"; r = sx32(32'(a[0]) + b[31:0]); end
            7'b0010100: begin tag = "R4"; r = {63'b0, s64[0]}; end
            7'b0010101: begin tag = "R4"; r = {56'b0, s64[7:0]}; end
            7'b0010110: begin tag = "R4"; r = {48'b0, s64[15:0]}; end
            7'b0010111: begin tag = "R4"; r = {{48{s64[15]}}, s64[15:0]}; end
            7'b0100001: begin tag = "R5"; r = s64; end
            7'b0100000: begin tag = "R5"; r = {32'b0, a[31:0]} + b; end
            7'b0100010: begin tag = "R5"; r = 64'(a[0]) + b; end
            7'b0101000: begin tag = "R6"; r = {31'b0, a[31:0], 1'b0} + b; end
            7'b0101001: begin tag = "R6"; r = a * 2 + b; end
            7'b0101010: begin tag = "R6"; r = {30'b0, a[31:0], 2'b0} + b; end
            7'b0101011: begin tag = "R6"; r = a * 4 + b; end
            7'b0101100: begin tag = "R6"; r = {29'b0, a[31:0], 3'b0} + b; end
            7'b0101101: begin tag = "R6"; r = a * 8 + b; end
            7'b0101111: begin tag = "R6"; r = a * 16 + b; end
            7'b0100100: begin tag = "R7"; r = {29'b0, a[63:29]} + b; end
            7'b0100101: begin tag = "R7"; r = {30'b0, a[63:30]} + b; end
            7'b0100110: begin tag = "R7"; r = {31'b0, a[63:31]} + b; end
            7'b0100111: begin tag = "R7"; r = {32'b0, a[63:32]} + b; end
            7'b0100011: begin tag = "R8"; r = {{52{b[11]}}, b[11:0]} + {b[63:12], 12'b0}; end
            7'b0010011: begin tag = "R8"; r = sx32({{20{b[11]}}, b[11:0]} + {b[31:12], 12'b0}); end
            7'b0110000: begin tag = "R9"; r = a - b; end
            7'b0110001: begin tag = "R9"; r = (a < b) ? 64'd1 : 64'd0; end
            7'b0110010: begin tag = "R9"; r = ($signed(a) < $signed(b)) ? 64'd1 : 64'd0; end
            7'b0110100: begin tag = "R9"; r = (a > b) ? a : b; end
            7'b0110101: begin tag = "R9"; r = (a > b) ? b : a; end
            7'b0110110: begin tag = "R9"; r = ($signed(a) > $signed(b)) ? a : b; end
            7'b0110111: begin tag = "R9"; r = ($signed(a) > $signed(b)) ? b : a; end
            7'b1001000: begin tag = "R11"; r = {{56{a[7]}}, a[7:0]}; end
            7'b1001010: begin tag = "R11"; r = {{48{a[15]}}, a[15:0]}; end
            7'b1001001: begin tag = "R11"; r = {48'b0, b[7:0], a[7:0]}; end
            7'b1001011: begin tag = "R11"; r = sx32({b[15:0], a[15:0]}); end
            7'b1010010: begin tag = "R11"; r = {b[31:0], a[31:0]}; end
            7'b1010001: begin tag = "R11"; for (int k = 0; k < 8; k++) r[8*k +: 8] = a[8*(7-k) +: 8]; end
            default: begin
                if (c[6:3] == 4'b1000 && c[2:0] != 3'b111) begin
                    tag = "R10"; r = plain_logic(c[2:0], a, b);
                end else if (c[6:4] == 3'b110 && c[3:1] != 3'b111) begin
                    tag = "R12"; s64 = plain_logic(c[3:1], a, b);
                    r = c[0] ? {48'b0, s64[15:0]} : {63'b0, s64[0]};
                end
            end
        endcase
        return r;
    endfunction

    function automatic logic [63:0] corner(input int i);
        case (i)
            0:  return 64'h0;
            1:  return 64'hFFFF_FFFF_FFFF_FFFF;
            2:  return 64'h1;
            3:  return 64'h8000_0000_0000_0000;
            4:  return 64'h0000_0000_8000_0000;
            5:  return 64'h7FFF_FFFF_FFFF_FFFF;
            6:  return 64'hFFFF_FFFF_0000_0000;
            7:  return 64'h0123_4567_89AB_CDEF;
            8:  return 64'h3F;
            9:  return 64'h20;
            10: return 64'h1F;
            11: return 64'hFFFF_FFFF_FFFF_F800;
            12: return 64'h0000_0000_0000_0800;
            13: return 64'h00FF_0000_FF00_8000;
            14: return 64'hFEDC_BA98_7654_3210;
            default: return 64'h0000_0001_FFFF_FFC1;
        endcase
    endfunction

    task automatic apply(input logic [6:0] c, input logic [63:0] a, input logic [63:0] b);
        logic [63:0] exp;
        string tag;
        @(negedge clk);
        op = c; src_a = a; src_b = b;
        #1;
        exp = model(c, a, b, tag);
        n_vec++;
        if (result !== exp) begin
            n_fail++;
            $display("FAIL %s op=%b a=%h b=%h actual=%h expected=%h", tag, c, a, b, result, exp);
        end
    endtask

    function automatic logic [63:0] next_rng(input logic [63:0] x);
        logic [63:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 7);
        return y ^ (y << 17);
    endfunction

    bit done = 1'b0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        op = '0; src_a = '0; src_b = '0;
        // idle state: zero operands under code 0 (R1) give zero
        apply(7'd0, 64'd0, 64'd0);
        // all codes, R1 through R13, across the corner grid
        for (int c = 0; c < 128; c++)
            for (int i = 0; i < 16; i++)
                for (int j = 0; j < 16; j++)
                    apply(7'(c), corner(i), corner(j));
        // all codes with pseudo-random operands
        for (int n = 0; n < 64; n++) begin
            logic [63:0] ra, rb;
            rng = next_rng(rng); ra = rng;
            rng = next_rng(rng); rb = rng;
            for (int c = 0; c < 128; c++) apply(7'(c), ra, rb);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule